// File: doc/BRIEF.md
# Serial Addressed Configuration Register Bank

This block holds four small configuration registers that are loaded over a three-wire serial port: a data line, a shift clock and a latch strobe. Each serial transfer carries one 8-bit word. The two low bits of the word are an address that picks a register. The upper six bits are the payload for that register. The registers feed a two-channel converter, a threshold detector and trigger logic as parallel fields. Those consumers sit outside this block.

The serial clock, data and latch lines come from outside the system clock domain. Each one passes through a two-flop synchroniser before the block uses it. Bits are shifted in most significant bit first, on each rising edge of the serial clock. A rising edge on the latch line commits the last eight bits.

A busy input marks an active conversion cycle, and configuration must not change while it is high. A latch that arrives during busy is not lost. It is parked as a single pending write, and a later latch overwrites it. The pending write lands as soon as busy drops. Every real register update raises a one-cycle strobe that carries the target address.

Top module: `cfg_serial_bank`

## Requirements
- R1: Serial data is captured on each synchronised rising edge of `ser_clk`, most significant bit first. A synchronised rising edge of `ser_lat` commits the last eight bits captured.
- R2: Word bits 1:0 select the target register: 00 is channel 1, 01 is channel 2, 10 is threshold control and 11 is pre-trigger control. A write changes no register other than the one addressed.
- R3: For the channel registers, word bits 7:4 become the channel's conversion mode and word bit 3 becomes its offset-calibration enable.
- R4: After reset, both channel modes are 4'b1100 with calibration disabled, threshold time is 3'b100, threshold level is 2'b00 and pre-trigger mode is 2'b00.
- R5: For the threshold register, word bits 7:5 become the detection time and word bits 4:3 become the threshold level.
- R6: For the pre-trigger register, word bits 7:6 become the pre-trigger mode.
- R7: Reserved payload bits are stored as zero and have no effect on any output. These are word bit 2 for the channel and threshold registers, and word bits 5:2 for the pre-trigger register.
- R8: While `busy` is high, no register changes and no strobe is raised. A latch seen during busy is applied in the first cycle in which busy is low, so its strobe is visible one clock later.
- R9: A newer latch seen during busy replaces any older pending write. Only the newest one is applied.
- R10: `wr_stb` is high for one cycle, with `wr_addr` holding the register address, for each register update and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_lat | input | 1 | Serial latch strobe, asynchronous |
| busy | input | 1 | Conversion cycle in progress |
| ch1_mode | output | 4 | Channel 1 conversion mode |
| ch1_cal | output | 1 | Channel 1 offset-calibration enable |
| ch2_mode | output | 4 | Channel 2 conversion mode |
| ch2_cal | output | 1 | Channel 2 offset-calibration enable |
| thr_time | output | 3 | Threshold detection time |
| thr_level | output | 2 | Threshold level |
| pt_mode | output | 2 | Pre-trigger mode |
| wr_stb | output | 1 | One-cycle register update strobe |
| wr_addr | output | 2 | Address of the register just updated |

## Verification
The bench sends words with every reserved bit set high and checks that none of them reach an output. A design that stored those bits unmasked, or shifted a field by one position, would show a wrong mode, time or level. It latches a word during busy and checks that there is no strobe and no output change until busy falls, and that the strobe appears exactly one clock after that. A design that dropped the deferred write, or applied it early, would miss the expected cycle. It also issues two latches inside one busy window. A design that kept the older write, or applied both, would produce a spurious channel-1 change or an extra strobe.

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_dat,
  input  logic       ser_clk,
  input  logic       ser_lat,
  input  logic       busy,
  output logic [3:0] ch1_mode,
  output logic       ch1_cal,
  output logic [3:0] ch2_mode,
  output logic       ch2_cal,
  output logic [2:0] thr_time,
  output logic [1:0] thr_level,
  output logic [1:0] pt_mode,
  output logic       wr_stb,
  output logic [1:0] wr_addr
);

  logic [SYNC:0]   s_clk, s_lat;
  logic [SYNC-1:0] s_dat;
  logic [7:0]      sh, pend_w, wr_word;
  logic            pend_v, do_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_clk <= '0;
      s_lat <= '0;
      s_dat <= '0;
    end else begin
      s_clk <= {s_clk[SYNC-1:0], ser_clk};
      s_lat <= {s_lat[SYNC-1:0], ser_lat};
      s_dat <= {s_dat[SYNC-2:0], ser_dat};
    end
  end

  wire clk_rise = s_clk[SYNC-1] & ~s_clk[SYNC];
  wire lat_rise = s_lat[SYNC-1] & ~s_lat[SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else if (clk_rise) sh <= {sh[6:0], s_dat[SYNC-1]};
  end

  always_comb begin
    do_wr   = 1'b0;
    wr_word = sh;
    if (!busy) begin
      if (lat_rise) begin
        do_wr   = 1'b1;
        wr_word = sh;
      end else if (pend_v) begin
        do_wr   = 1'b1;
        wr_word = pend_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_w <= '0;
    end else if (busy && lat_rise) begin
      pend_v <= 1'b1;
      pend_w <= sh;
    end else if (!busy) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch1_mode  <= 4'b1100;
      ch1_cal   <= 1'b0;
      ch2_mode  <= 4'b1100;
      ch2_cal   <= 1'b0;
      thr_time  <= 3'b100;
      thr_level <= 2'b00;
      pt_mode   <= 2'b00;
      wr_stb    <= 1'b0;
      wr_addr   <= 2'b00;
    end else begin
      wr_stb <= do_wr;
      if (do_wr) begin
        wr_addr <= wr_word[1:0];
        case (wr_word[1:0])
          2'd0: begin ch1_mode <= wr_word[7:4]; ch1_cal <= wr_word[3]; end
          2'd1: begin ch2_mode <= wr_word[7:4]; ch2_cal <= wr_word[3]; end
          2'd2: begin thr_time <= wr_word[7:5]; thr_level <= wr_word[4:3]; end
          default: pt_mode <= wr_word[7:6];
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_serial_bank_chk.sv
module cfg_serial_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [3:0] ch1_mode,
  input logic       ch1_cal,
  input logic [3:0] ch2_mode,
  input logic       ch2_cal,
  input logic [2:0] thr_time,
  input logic [1:0] thr_level,
  input logic [1:0] pt_mode,
  input logic       wr_stb,
  input logic [1:0] wr_addr
);

  wire [16:0] cfg = {ch1_mode, ch1_cal, ch2_mode, ch2_cal, thr_time, thr_level, pt_mode};

  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg) && !wr_stb));

  a_r10_change_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(cfg));

  a_r2_ch1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != 2'd0) |-> ($stable(ch1_mode) && $stable(ch1_cal)));

  a_r2_ch2_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != 2'd1) |-> ($stable(ch2_mode) && $stable(ch2_cal)));

endmodule

bind cfg_serial_bank cfg_serial_bank_chk u_chk (.*);

// File: tb/sim_cfg_serial_bank.sv
module sim_cfg_serial_bank;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, ser_dat = 0, ser_clk = 0, ser_lat = 0, busy = 0;
  logic [3:0] ch1_mode, ch2_mode;
  logic ch1_cal, ch2_cal, wr_stb;
  logic [2:0] thr_time;
  logic [1:0] thr_level, pt_mode, wr_addr;

  cfg_serial_bank u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, stb_cnt = 0, exp_stb = 0;
  logic [18:0] q[$];
  string tq[$];
  logic [16:0] shadow = {4'b1100, 1'b0, 4'b1100, 1'b0, 3'b100, 2'b00, 2'b00};

  wire [16:0] cfg = {ch1_mode, ch1_cal, ch2_mode, ch2_cal, thr_time, thr_level, pt_mode};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] w, input bit expect_wr, input string tag);
    if (expect_wr) begin
      case (w[1:0])
        2'd0: begin shadow[16:13] = w[7:4]; shadow[12] = w[3]; end
        2'd1: begin shadow[11:8] = w[7:4]; shadow[7] = w[3]; end
        2'd2: begin shadow[6:4] = w[7:5]; shadow[3:2] = w[4:3]; end
        default: shadow[1:0] = w[7:6];
      endcase
      q.push_back({w[1:0], shadow});
      tq.push_back(tag);
      exp_stb++;
    end
    for (int i = 7; i >= 0; i--) begin
      ser_dat = w[i];
      wait_clk(3);
      ser_clk = 1;
      wait_clk(3);
      ser_clk = 0;
      wait_clk(3);
    end
    ser_lat = 1;
    wait_clk(3);
    ser_lat = 0;
    wait_clk(6);
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      logic [18:0] e;
      string t;
      stb_cnt++;
      if (q.size() == 0) begin
        check(0, "R10 unexpected strobe", {13'd0, wr_addr, cfg}, 32'd0);
      end else begin
        e = q.pop_front();
        t = tq.pop_front();
        check({wr_addr, cfg} == e, t, {13'd0, wr_addr, cfg}, {13'd0, e});
      end
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int s0;
    wait_clk(4);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cfg == shadow && !wr_stb, "R4 reset values", {15'd0, cfg}, {15'd0, shadow});

    send(8'b10101100, 1, "R3 R7 ch1 mode/cal, bit2 ignored");
    send(8'b01110001, 1, "R2 R3 ch2 write");
    send(8'b01110110, 1, "R5 R7 threshold time/level");
    send(8'b11111111, 1, "R6 R7 pre-trigger, reserved ignored");
    send(8'b01000011, 1, "R6 pre-trigger 01");
    send(8'b00010000, 1, "R1 MSB-first ch1 0001");
    @(negedge clk);
    check(cfg == shadow, "R2 R7 state after sequence", {15'd0, cfg}, {15'd0, shadow});

    busy = 1;
    s0 = stb_cnt;
    send(8'b10011001, 1, "R8 deferred ch2 write");
    wait_clk(5);
    @(negedge clk);
    check(stb_cnt == s0, "R8 no strobe during busy", stb_cnt, s0);
    check(ch2_mode == 4'b0111, "R8 ch2 held during busy", {28'd0, ch2_mode}, 32'd7);
    busy = 0;
    @(negedge clk);
    check(wr_stb == 1 && wr_addr == 2'd1, "R8 strobe one clock after busy falls", {30'd0, wr_addr}, 32'd1);

    wait_clk(4);
    busy = 1;
    send(8'b11110100, 0, "R9 superseded");
    send(8'b10001010, 1, "R9 newest pending thr write");
    s0 = stb_cnt;
    @(negedge clk);
    busy = 0;
    wait_clk(6);
    @(negedge clk);
    check(stb_cnt == s0 + 1, "R9 only one deferred write", stb_cnt, s0 + 1);
    check(ch1_mode == 4'b0001, "R9 superseded ch1 write dropped", {28'd0, ch1_mode}, 32'd1);
    check(q.size() == 0 && stb_cnt == exp_stb, "R10 strobe count", stb_cnt, exp_stb);
    summary();
  end
endmodule